// File: doc/BRIEF.md
# DMA Address Extension and End-of-Frame Gate

This block joins a four-channel DMA controller to a network controller's transmit and receive FIFOs. The controller emits only the low address byte directly. During an address strobe it also drives the middle address byte on its data bus. The block captures that middle byte into a register, and it takes the top byte from a page register written by the host. While one of the two used channels is acknowledged, it presents the full 24-bit memory address. Channel 0 fills the transmit FIFO and channel 1 empties the receive FIFO. Acknowledges are active low and end-of-process is active low.

The controller pulses end-of-process each time its transfer count runs out, which is once per buffer. The network side needs end-of-frame only once per packet. To arm forwarding for a packet's final buffer, the host raises a last-buffer flag. A transmit-channel end-of-process then reaches the network side as an end-of-frame pulse only while that flag is set. Issuing the pulse clears the flag. End-of-process seen on the receive channel is never forwarded, because receive frame boundaries come from the network side.

Top module: `dma_addr_eof_glue`

## Requirements
- R1: A synchronous active-high reset clears the middle-byte register, the page register and the last-buffer flag. After reset, an acknowledged address reads as zero in bits 23:8.
- R2: At a clock edge where `dma_adstb` is high, the middle-byte register loads `dma_db`. At every other edge it holds its value. It appears as address bits 15:8 from the next cycle on.
- R3: At a clock edge where `host_page_ld` is high, the page register loads `host_wdata`. At every other edge it holds its value. It appears as address bits 23:16 from the next cycle on.
- R4: When `dma_dack_n` is 2'b10 (channel 0, transmit) or 2'b01 (channel 1, receive), `addr_valid` is 1 in the same cycle. In that case `mem_addr` equals {page, middle byte, `dma_lo_addr`}.
- R5: When `dma_dack_n` is 2'b11 or 2'b00, `addr_valid` is 0 and `mem_addr` is 0.
- R6: `tx_eof` is 1 in the same cycle only when all three hold: `dma_eop_n` is 0, `dma_dack_n` is 2'b10, and the last-buffer flag is set.
- R7: At an edge where `host_last_set` is high, the flag becomes set, even if `tx_eof` is high in that cycle. Otherwise, at an edge where `tx_eof` is high, the flag clears. `last_flag` shows the flag.
- R8: End-of-process while `dma_dack_n` is 2'b01 never raises `tx_eof` and leaves the flag unchanged.
- R9: End-of-process on the transmit channel while the flag is clear gives no `tx_eof`. This covers the buffers of a packet before its last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the DMA controller |
| rst | input | 1 | Synchronous reset, active high |
| dma_db | input | 8 | DMA data bus; it carries address bits 15:8 during the strobe |
| dma_adstb | input | 1 | Address strobe, active high |
| dma_lo_addr | input | 8 | Low address byte from the DMA controller |
| dma_dack_n | input | 2 | Acknowledges, active low; bit 0 is transmit, bit 1 is receive |
| dma_eop_n | input | 1 | End-of-process, active low |
| host_wdata | input | 8 | Host write data for the page register |
| host_page_ld | input | 1 | Host strobe that loads the page register |
| host_last_set | input | 1 | Host strobe that arms the last-buffer flag |
| mem_addr | output | 24 | Rebuilt memory address; zero when not valid |
| addr_valid | output | 1 | High while exactly one used channel is acknowledged |
| tx_eof | output | 1 | End-of-frame to the transmit FIFO, active high |
| last_flag | output | 1 | Current state of the last-buffer flag |

## Verification
If the middle-byte or page register is corrupted, it shows up in bits 15:8 or 23:16 of `mem_addr` on the first acknowledged cycle after the faulty edge. It stays wrong until the next strobe or host load rewrites it. If the flag is wrong, `last_flag` shows it in the very next cycle. `tx_eof` also goes wrong on the next transmit end-of-process: it either drops a packet end or sends a packet end early after a middle buffer. Because every output is compared with a model in every cycle, under random and directed acknowledge, strobe and end-of-process patterns, each such fault is caught within one cycle of reaching a port.

// File: rtl/dma_addr_eof_glue.sv
module dma_addr_eof_glue #(
  parameter int LO_W   = 8,
  parameter int MID_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [MID_W-1:0]              dma_db,
  input  logic                          dma_adstb,
  input  logic [LO_W-1:0]               dma_lo_addr,
  input  logic [1:0]                    dma_dack_n,
  input  logic                          dma_eop_n,
  input  logic [PAGE_W-1:0]             host_wdata,
  input  logic                          host_page_ld,
  input  logic                          host_last_set,
  output logic [LO_W+MID_W+PAGE_W-1:0]  mem_addr,
  output logic                          addr_valid,
  output logic                          tx_eof,
  output logic                          last_flag
);
  localparam int ADDR_W = LO_W + MID_W + PAGE_W;

  logic [MID_W-1:0]  mid_q;
  logic [PAGE_W-1:0] page_q;
  logic              flag_q;
  logic              tx_ack, rx_ack;

  assign tx_ack     = (dma_dack_n == 2'b10);
  assign rx_ack     = (dma_dack_n == 2'b01);
  assign addr_valid = tx_ack | rx_ack;
  assign mem_addr   = addr_valid ? {page_q, mid_q, dma_lo_addr} : {ADDR_W{1'b0}};
  assign tx_eof     = tx_ack & ~dma_eop_n & flag_q;
  assign last_flag  = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q  <= '0;
      page_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (dma_adstb)         mid_q  <= dma_db;
      if (host_page_ld)      page_q <= host_wdata;
      if (host_last_set)     flag_q <= 1'b1;
      else if (tx_eof)       flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_addr_eof_glue_chk.sv
module dma_addr_eof_glue_chk #(
  parameter int LO_W   = 8,
  parameter int MID_W  = 8,
  parameter int PAGE_W = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic [MID_W-1:0]             dma_db,
  input logic                         dma_adstb,
  input logic [LO_W-1:0]              dma_lo_addr,
  input logic [1:0]                   dma_dack_n,
  input logic                         dma_eop_n,
  input logic [PAGE_W-1:0]            host_wdata,
  input logic                         host_page_ld,
  input logic                         host_last_set,
  input logic [LO_W+MID_W+PAGE_W-1:0] mem_addr,
  input logic                         addr_valid,
  input logic                         tx_eof,
  input logic                         last_flag
);
  localparam int MID_LO = LO_W;
  localparam int PG_LO  = LO_W + MID_W;

  AST_MID_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    dma_adstb && addr_valid |=> !addr_valid || mem_addr[PG_LO-1:MID_LO] == $past(dma_db)); // R2
  AST_PAGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    host_page_ld && addr_valid |=> !addr_valid || mem_addr[PG_LO+PAGE_W-1:PG_LO] == $past(host_wdata)); // R3
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> mem_addr[LO_W-1:0] == dma_lo_addr); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |-> mem_addr == '0); // R5
  AST_EOF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    tx_eof |-> last_flag && !dma_eop_n); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    tx_eof && !host_last_set |=> !last_flag); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    host_last_set |=> last_flag); // R7
  AST_RX_NO_EOF: assert property (@(posedge clk) disable iff (rst)
    dma_dack_n == 2'b01 |-> !tx_eof); // R8
  AST_RX_FLAG_KEPT: assert property (@(posedge clk) disable iff (rst)
    dma_dack_n == 2'b01 && !host_last_set |=> $stable(last_flag)); // R8
  AST_MID_BUF_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    !last_flag |-> !tx_eof); // R9
endmodule

bind dma_addr_eof_glue dma_addr_eof_glue_chk #(.LO_W(LO_W), .MID_W(MID_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .dma_db(dma_db), .dma_adstb(dma_adstb), .dma_lo_addr(dma_lo_addr),
  .dma_dack_n(dma_dack_n), .dma_eop_n(dma_eop_n), .host_wdata(host_wdata),
  .host_page_ld(host_page_ld), .host_last_set(host_last_set), .mem_addr(mem_addr),
  .addr_valid(addr_valid), .tx_eof(tx_eof), .last_flag(last_flag));

// File: tb/dma_addr_eof_glue_test.sv
module dma_addr_eof_glue_test;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  dma_db = 0, dma_lo_addr = 0, host_wdata = 0;
  logic        dma_adstb = 0, dma_eop_n = 1, host_page_ld = 0, host_last_set = 0;
  logic [1:0]  dma_dack_n = 2'b11;
  logic [23:0] mem_addr;
  logic        addr_valid, tx_eof, last_flag;

  dma_addr_eof_glue uut (
    .clk(clk), .rst(rst), .dma_db(dma_db), .dma_adstb(dma_adstb), .dma_lo_addr(dma_lo_addr),
    .dma_dack_n(dma_dack_n), .dma_eop_n(dma_eop_n), .host_wdata(host_wdata),
    .host_page_ld(host_page_ld), .host_last_set(host_last_set), .mem_addr(mem_addr),
    .addr_valid(addr_valid), .tx_eof(tx_eof), .last_flag(last_flag));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int m_page = 0, m_mid = 0;
  bit m_flag = 0;
  string cur_tag = "R1";
  bit done = 0;

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic bit m_valid();
    return dma_dack_n == 2'b10 || dma_dack_n == 2'b01;
  endfunction

  function automatic bit m_eof();
    return !dma_eop_n && dma_dack_n == 2'b10 && m_flag;
  endfunction

  task automatic compare();
    string et;
    int ea;
    ea = m_valid() ? (m_page << 16) | (m_mid << 8) | int'(dma_lo_addr) : 0;
    if (!dma_eop_n && dma_dack_n == 2'b01) et = "R8";
    else if (!dma_eop_n && dma_dack_n == 2'b10 && !m_flag) et = "R9";
    else et = "R6";
    chk(m_valid() ? cur_tag : "R5", "mem_addr", int'(mem_addr), ea);
    chk(m_valid() ? "R4" : "R5", "addr_valid", int'(addr_valid), int'(m_valid()));
    chk(et, "tx_eof", int'(tx_eof), int'(m_eof()));
    chk(rst ? "R1" : "R7", "last_flag", int'(last_flag), int'(m_flag));
  endtask

  task automatic step(bit r, logic [1:0] dk, bit eopn, bit stb, logic [7:0] db, logic [7:0] lo,
                      bit pld, logic [7:0] wd, bit ls);
    @(negedge clk);
    rst = r; dma_dack_n = dk; dma_eop_n = eopn; dma_adstb = stb; dma_db = db;
    dma_lo_addr = lo; host_page_ld = pld; host_wdata = wd; host_last_set = ls;
    #1 compare();
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_page = 0; m_mid = 0; m_flag = 0;
    end else begin
      bit e;
      e = m_eof();
      if (dma_adstb) m_mid = int'(dma_db);
      if (host_page_ld) m_page = int'(host_wdata);
      if (host_last_set) m_flag = 1;
      else if (e) m_flag = 0;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(1, 2'b11, 1, 0, 8'h00, 8'h00, 0, 8'h00, 0);
    step(1, 2'b10, 1, 1, 8'hAA, 8'h11, 1, 8'hBB, 1);
    cur_tag = "R1";
    step(0, 2'b10, 1, 0, 8'h00, 8'h5A, 0, 8'h00, 0);
    cur_tag = "R2";
    step(0, 2'b11, 1, 1, 8'h3C, 8'h00, 0, 8'h00, 0);
    step(0, 2'b10, 1, 0, 8'hFF, 8'h5A, 0, 8'h00, 0);
    step(0, 2'b01, 1, 0, 8'h77, 8'hA5, 0, 8'h00, 0);
    cur_tag = "R3";
    step(0, 2'b11, 1, 0, 8'h00, 8'h00, 1, 8'h81, 0);
    step(0, 2'b10, 1, 0, 8'h00, 8'h07, 0, 8'h42, 0);
    cur_tag = "R4";
    step(0, 2'b00, 1, 0, 8'h00, 8'h07, 0, 8'h00, 0);
    step(0, 2'b10, 0, 0, 8'h00, 8'h08, 0, 8'h00, 0);
    step(0, 2'b11, 1, 0, 8'h00, 8'h00, 0, 8'h00, 1);
    step(0, 2'b01, 0, 0, 8'h00, 8'h09, 0, 8'h00, 0);
    step(0, 2'b10, 0, 0, 8'h00, 8'h0A, 0, 8'h00, 0);
    step(0, 2'b10, 0, 0, 8'h00, 8'h0B, 0, 8'h00, 0);
    step(0, 2'b11, 1, 0, 8'h00, 8'h00, 0, 8'h00, 1);
    step(0, 2'b10, 0, 0, 8'h00, 8'h0C, 0, 8'h00, 1);
    step(0, 2'b10, 0, 0, 8'h00, 8'h0D, 0, 8'h00, 0);
    step(0, 2'b10, 1, 0, 8'h00, 8'h0E, 0, 8'h00, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] dk;
      int pick;
      pick = $urandom_range(0, 9);
      dk = (pick < 4) ? 2'b10 : (pick < 7) ? 2'b01 : (pick < 9) ? 2'b11 : 2'b00;
      step(($urandom_range(0, 199) == 0), dk, ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 4) == 0), 8'($urandom), 8'($urandom),
           ($urandom_range(0, 9) == 0), 8'($urandom), ($urandom_range(0, 7) == 0));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule